// File: doc/BRIEF.md
# Tiered Receive Ring Steering Unit

This block sits in the receive path of a network adapter that is attached to one compute cluster of a multi-cluster processor. Each cluster owns one physical receive ring, and that ring lives in the cluster's own memory region. For each incoming packet descriptor, the block picks the ring that receives the packet, stamps the packet with an arrival-order sequence number, and hands the result downstream on a valid/ready output.

Packets normally go to the ring of the attached cluster, so they land in that cluster's cache. The block keeps a running estimate of how much of that cache holds unread packet data. Each packet it forwards adds its length to the estimate. Once per fixed tick, the estimate drops by a per-tick consumption figure that host software computes and writes in from time to time. When the estimate climbs to a high threshold, packets are spread round-robin over the other clusters' rings. The block returns to the local ring only once the estimate falls below a lower threshold.

The block tracks a head and tail index for every ring so that it never writes into a full ring. If every ring is full, the packet is dropped and counted. The host merges the rings back into order by comparing the sequence numbers at the ring heads.

Top module: `rx_ring_steer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, occ_est is 0, remote_mode is 0 and drop_cnt is 0. The first forwarded packet carries sequence number 0.
- R2: While remote_mode is 0 and the local ring (index LOCAL_RING) is not full, every accepted packet is forwarded with out_ring equal to LOCAL_RING.
- R3: Each forwarded packet adds its length to occ_est, saturating at 2^OCC_W-1. The new value is visible one cycle after acceptance. A dropped packet adds nothing.
- R4: Once every TICK_CYCLES clock cycles, occ_est is reduced by the value most recently written through rate_we/rate_bytes, and it never goes below 0. With no traffic, two samples TICK_CYCLES cycles apart differ by exactly that rate while the estimate stays above it.
- R5: remote_mode is set when occ_est is at least HI_THR and is cleared only when occ_est is below LO_THR. Between the two thresholds it keeps its value. The flag follows occ_est one cycle later.
- R6: A remote ring is chosen when remote_mode is 1, or when the local ring is full. The search is round-robin over the non-local rings that are not full. It starts at the ring after the last remote ring chosen, or after LOCAL_RING following reset, and skips full rings. The local ring is used in remote mode only when no remote ring has room.
- R7: A ring is full when its tail minus its head, modulo 2^PTR_W, equals DEPTH. The tail advances by one on each packet forwarded to that ring. A pulse on head_we sets the head of ring head_ring to head_ptr.
- R8: When every ring, including the local one, is full, an accepted packet is dropped. No output appears, drop_cnt increases by one, occ_est is unchanged and no sequence number is consumed.
- R9: The sequence number increases by one, modulo 2^32, for each forwarded packet.
- R10: An accepted packet appears on out_valid/out_ring/out_seq/out_len in the following cycle. The output is held stable while out_ready is 0. in_ready equals !out_valid || out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet descriptor offered |
| in_ready | output | 1 | Descriptor accepted this cycle when in_valid is 1 |
| in_len | input | LEN_W | Packet length in bytes |
| out_valid | output | 1 | Steering result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_ring | output | $clog2(NRINGS) | Selected ring index |
| out_seq | output | 32 | Arrival-order sequence number |
| out_len | output | LEN_W | Packet length |
| rate_we | input | 1 | Load a new per-tick consumption figure |
| rate_bytes | input | OCC_W | Bytes consumed by the host per tick |
| head_we | input | 1 | Host head index update |
| head_ring | input | $clog2(NRINGS) | Ring whose head is written |
| head_ptr | input | $clog2(DEPTH)+1 | New head index, including the wrap bit |
| occ_est | output | OCC_W | Current occupancy estimate |
| remote_mode | output | 1 | Steering is currently spilling to remote rings |
| drop_cnt | output | CNT_W | Dropped packet count, wrapping |

## Verification
A wrong tail or head index shows up as a full ring. That ring is then skipped, or a packet is dropped, on the very next packet steered toward it, so out_ring or drop_cnt is wrong one cycle after acceptance. A fault in the estimate is visible on occ_est in the cycle after the packet or tick that caused it. The same fault reaches out_ring, through remote_mode, one cycle after that. A wrong round-robin pointer shows up as a wrong out_ring on the next remote choice, and a wrong sequence counter as a wrong out_seq on the next forwarded packet.

// File: rtl/rx_ring_steer.sv
module rx_ring_steer #(
  parameter int NRINGS      = 4,
  parameter int LOCAL_RING  = 1,
  parameter int DEPTH       = 8,
  parameter int LEN_W       = 16,
  parameter int OCC_W       = 20,
  parameter int HI_THR      = 4096,
  parameter int LO_THR      = 1024,
  parameter int TICK_CYCLES = 32,
  parameter int CNT_W       = 16,
  localparam int RID_W = $clog2(NRINGS),
  localparam int PTR_W = $clog2(DEPTH) + 1,
  localparam int TK_W  = $clog2(TICK_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RID_W-1:0] out_ring,
  output logic [31:0]      out_seq,
  output logic [LEN_W-1:0] out_len,
  input  logic             rate_we,
  input  logic [OCC_W-1:0] rate_bytes,
  input  logic             head_we,
  input  logic [RID_W-1:0] head_ring,
  input  logic [PTR_W-1:0] head_ptr,
  output logic [OCC_W-1:0] occ_est,
  output logic             remote_mode,
  output logic [CNT_W-1:0] drop_cnt
);
  localparam int SUM_W = OCC_W + 2;
  localparam logic [OCC_W-1:0] HI_V  = OCC_W'(HI_THR);
  localparam logic [OCC_W-1:0] LO_V  = OCC_W'(LO_THR);
  localparam logic [SUM_W-1:0] MAX_V = SUM_W'({OCC_W{1'b1}});
  localparam logic [RID_W-1:0] LOC_V = RID_W'(LOCAL_RING);

  logic [PTR_W-1:0] head_q [NRINGS];
  logic [PTR_W-1:0] tail_q [NRINGS];
  logic [NRINGS-1:0] full;
  logic [OCC_W-1:0] occ_q, rate_q;
  logic [TK_W-1:0]  tk_q;
  logic [RID_W-1:0] rr_q, rem_pick, target;
  logic [31:0]      seq_q;
  logic             remote_q, rem_hit, use_local, drop, accept, enq, tick;
  logic [SUM_W-1:0] sum_a, sum_b;

  for (genvar g = 0; g < NRINGS; g++) begin : g_full
    assign full[g] = (tail_q[g] - head_q[g]) == PTR_W'(DEPTH);
  end

  always_comb begin
    rem_hit  = 1'b0;
    rem_pick = LOC_V;
    for (int k = 1; k <= NRINGS; k++) begin
      int idx;
      idx = int'(rr_q) + k;
      if (idx >= NRINGS) idx = idx - NRINGS;
      if (!rem_hit && idx != LOCAL_RING && !full[idx]) begin
        rem_hit  = 1'b1;
        rem_pick = RID_W'(idx);
      end
    end
  end

  assign use_local = !full[LOCAL_RING] && (!remote_q || !rem_hit);
  assign drop      = !use_local && !rem_hit;
  assign target    = use_local ? LOC_V : rem_pick;
  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign enq       = accept && !drop;
  assign tick      = tk_q == TK_W'(TICK_CYCLES - 1);

  always_comb begin
    sum_a = SUM_W'(occ_q) + (enq ? SUM_W'(in_len) : '0);
    if (sum_a > MAX_V) sum_a = MAX_V;
    sum_b = sum_a;
    if (tick) sum_b = (sum_a >= SUM_W'(rate_q)) ? sum_a - SUM_W'(rate_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q     <= '0;
      rate_q    <= '0;
      tk_q      <= '0;
      remote_q  <= 1'b0;
      rr_q      <= LOC_V;
      seq_q     <= '0;
      drop_cnt  <= '0;
      out_valid <= 1'b0;
      out_ring  <= '0;
      out_seq   <= '0;
      out_len   <= '0;
      for (int i = 0; i < NRINGS; i++) begin
        head_q[i] <= '0;
        tail_q[i] <= '0;
      end
    end else begin
      occ_q    <= sum_b[OCC_W-1:0];
      tk_q     <= tick ? '0 : tk_q + 1'b1;
      remote_q <= remote_q ? (occ_q >= LO_V) : (occ_q >= HI_V);
      if (rate_we) rate_q <= rate_bytes;
      if (head_we && int'(head_ring) < NRINGS) head_q[head_ring] <= head_ptr;
      if (accept && drop) drop_cnt <= drop_cnt + 1'b1;
      if (enq) begin
        tail_q[target] <= tail_q[target] + 1'b1;
        if (!use_local) rr_q <= target;
        seq_q     <= seq_q + 32'd1;
        out_valid <= 1'b1;
        out_ring  <= target;
        out_seq   <= seq_q;
        out_len   <= in_len;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign occ_est     = occ_q;
  assign remote_mode = remote_q;
endmodule

// File: rtl/rx_ring_steer_chk.sv
module rx_ring_steer_chk #(
  parameter int NRINGS     = 4,
  parameter int LOCAL_RING = 1,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [$clog2(NRINGS)-1:0] out_ring,
  input logic [31:0]               out_seq,
  input logic [LEN_W-1:0]          out_len,
  input logic [CNT_W-1:0]          drop_cnt,
  input logic                      remote_q,
  input logic                      rem_hit,
  input logic [NRINGS-1:0]         full
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ring) && $stable(out_seq) && $stable(out_len));

  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r9_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || out_seq == $past(out_seq) + 32'd1);

  a_r2_local_pref: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !remote_q && !full[LOCAL_RING] |=> out_valid && out_ring == ($clog2(NRINGS))'(LOCAL_RING));

  a_r6_spill_remote: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (remote_q || full[LOCAL_RING]) && rem_hit |=> out_valid && out_ring != ($clog2(NRINGS))'(LOCAL_RING));

  a_r8_drop_all_full: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !rem_hit && full[LOCAL_RING] |=> !out_valid && drop_cnt == $past(drop_cnt) + 1'b1);

  a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + 1'b1);
endmodule

bind rx_ring_steer rx_ring_steer_chk #(
  .NRINGS(NRINGS), .LOCAL_RING(LOCAL_RING), .LEN_W(LEN_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_ring(out_ring),
  .out_seq(out_seq), .out_len(out_len), .drop_cnt(drop_cnt),
  .remote_q(remote_q), .rem_hit(rem_hit), .full(full)
);

// File: tb/rx_ring_steer_tb_top.sv
module rx_ring_steer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, LOC = 1, DEPTH = 8, OCC_W = 16;
  localparam int HI = 4096, LO = 1024, TICK = 32;
  localparam int OMAX = (1 << OCC_W) - 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1, rate_we = 0, head_we = 0;
  logic [15:0] in_len = 0;
  logic [OCC_W-1:0] rate_bytes = 0;
  logic [1:0] head_ring = 0;
  logic [3:0] head_ptr = 0;
  logic in_ready, out_valid, remote_mode;
  logic [1:0] out_ring;
  logic [31:0] out_seq;
  logic [15:0] out_len, drop_cnt;
  logic [OCC_W-1:0] occ_est;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_steer #(.NRINGS(N), .LOCAL_RING(LOC), .DEPTH(DEPTH), .OCC_W(OCC_W),
    .HI_THR(HI), .LO_THR(LO), .TICK_CYCLES(TICK)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_ring(out_ring), .out_seq(out_seq),
    .out_len(out_len), .rate_we(rate_we), .rate_bytes(rate_bytes), .head_we(head_we),
    .head_ring(head_ring), .head_ptr(head_ptr), .occ_est(occ_est),
    .remote_mode(remote_mode), .drop_cnt(drop_cnt));

  int checks = 0, fails = 0;
  int m_occ = 0, m_rr = LOC, m_drop = 0;
  bit m_remote = 0;
  int m_head[N], m_tail[N];
  int unsigned m_seq = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic bit mfull(input int r);
    return ((m_tail[r] - m_head[r]) & 15) == DEPTH;
  endfunction

  function automatic int rem_choice();
    for (int k = 1; k <= N; k++) begin
      int r = (m_rr + k) % N;
      if (r != LOC && !mfull(r)) return r;
    end
    return -1;
  endfunction

  function automatic int pick();
    int rc = rem_choice();
    if (!mfull(LOC) && (!m_remote || rc < 0)) return LOC;
    return rc;
  endfunction

  task automatic enq_model(input int r, input int len);
    m_tail[r] = (m_tail[r] + 1) & 15;
    if (r != LOC) m_rr = r;
    m_seq = m_seq + 1;
    m_occ = (m_occ + len > OMAX) ? OMAX : m_occ + len;
  endtask

  task automatic settle();
    @(negedge clk);
    m_remote = m_remote ? (m_occ >= LO) : (m_occ >= HI);
  endtask

  task automatic send(input int len);
    int exp_r;
    exp_r = pick();
    chk(in_ready == 1, "R10 in_ready idle", in_ready, 1);
    in_valid = 1; in_len = 16'(len);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    if (exp_r < 0) begin
      m_drop++;
      chk(out_valid == 0, "R8 no output on drop", out_valid, 0);
      chk(drop_cnt == 16'(m_drop), "R8 drop count", drop_cnt, m_drop);
    end else begin
      chk(out_valid == 1, "R10 output valid", out_valid, 1);
      chk(out_ring == 2'(exp_r), (m_remote || mfull(LOC)) ? "R6 remote ring" : "R2 local ring",
          out_ring, exp_r);
      chk(out_seq == m_seq, "R9 sequence", out_seq, m_seq);
      chk(out_len == 16'(len), "R10 length", out_len, len);
      enq_model(exp_r, len);
    end
    chk(occ_est == OCC_W'(m_occ), "R3 estimate", occ_est, m_occ);
    settle();
  endtask

  task automatic free_ring(input int r);
    head_we = 1; head_ring = 2'(r); head_ptr = 4'(m_tail[r]);
    @(posedge clk);
    @(negedge clk);
    head_we = 0;
    m_head[r] = m_tail[r];
  endtask

  task automatic free_all();
    for (int r = 0; r < N; r++) free_ring(r);
  endtask

  task automatic set_rate(input int v);
    rate_we = 1; rate_bytes = OCC_W'(v);
    @(posedge clk);
    @(negedge clk);
    rate_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int a, b, l1, l2, e1, e2;
    bit seen_drop;
    void'($urandom(32'd2024));
    for (int r = 0; r < N; r++) begin m_head[r] = 0; m_tail[r] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(occ_est == 0, "R1 estimate", occ_est, 0);
    chk(remote_mode == 0, "R1 remote_mode", remote_mode, 0);
    chk(drop_cnt == 0, "R1 drop_cnt", drop_cnt, 0);

    // R1 R2: first packets local, sequence from zero
    for (int i = 0; i < 6; i++) begin
      send(64);
      free_ring(LOC);
    end

    // R2 R3 R5 R6 R7: random lengths with random host frees
    for (int i = 0; i < 80; i++) begin
      send(64 + int'($urandom % 1437));
      if ($urandom % 3 == 0) free_ring(int'($urandom % N));
      chk(remote_mode == m_remote, "R5 flag", remote_mode, m_remote);
    end

    // R7 R8: fill every ring until drops occur
    free_all();
    seen_drop = 0;
    for (int i = 0; i < 36; i++) begin
      if (pick() < 0) seen_drop = 1;
      send(64);
    end
    chk(seen_drop == 1 && drop_cnt == 16'(m_drop), "R7 all rings full", drop_cnt, m_drop);

    // R3: saturation
    free_all();
    send(65535);
    send(65535);
    chk(occ_est == OCC_W'(OMAX), "R3 saturation", occ_est, OMAX);

    // R10: backpressure holds output and blocks input
    free_all();
    out_ready = 0;
    l1 = 300; l2 = 500;
    e1 = pick();
    in_valid = 1; in_len = 16'(l1);
    @(posedge clk);
    @(negedge clk);
    in_len = 16'(l2);
    chk(out_valid == 1 && out_ring == 2'(e1), "R10 first held", out_ring, e1);
    enq_model(e1, l1);
    repeat (2) @(negedge clk);
    m_remote = m_remote ? (m_occ >= LO) : (m_occ >= HI);
    chk(in_ready == 0, "R10 in_ready low", in_ready, 0);
    chk(out_len == 16'(l1) && out_seq == m_seq - 1, "R10 stable output", out_len, l1);
    e2 = pick();
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 1 && out_len == 16'(l2), "R10 second after release", out_len, l2);
    chk(out_ring == 2'(e2), "R6 ring after release", out_ring, e2);
    chk(out_seq == m_seq, "R9 sequence after stall", out_seq, m_seq);
    enq_model(e2, l2);
    settle();

    // R4: tick decay by exactly the reported rate
    free_all();
    set_rate(1000);
    a = int'(occ_est);
    repeat (TICK) @(negedge clk);
    b = int'(occ_est);
    chk(a - b == 1000, "R4 per-tick decay", a - b, 1000);

    // R5: hysteresis keeps remote mode between thresholds
    for (int i = 0; i < 5000 && int'(occ_est) >= HI; i++) begin
      @(negedge clk);
      if (int'(occ_est) >= LO)
        chk(remote_mode == 1, "R5 held above low", remote_mode, 1);
    end
    rate_we = 1; rate_bytes = 0;
    @(posedge clk);
    @(negedge clk);
    rate_we = 0;
    repeat (2) @(negedge clk);
    m_occ = int'(occ_est);
    chk(m_occ >= LO && m_occ < HI, "R5 in band", m_occ, LO);
    chk(remote_mode == 1, "R5 band keeps remote", remote_mode, 1);
    m_remote = 1;
    send(100);

    // R4 R5: floor at zero, return to local
    set_rate(60000);
    for (int i = 0; i < 200 && occ_est != 0; i++) @(negedge clk);
    repeat (TICK + 2) @(negedge clk);
    chk(occ_est == 0, "R4 floor at zero", occ_est, 0);
    chk(remote_mode == 0, "R5 below low clears", remote_mode, 0);
    set_rate(0);
    m_occ = 0; m_remote = 0;
    free_all();
    send(200);

    summary();
    $finish;
  end
endmodule